// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small byte-addressed data cache placed between a processor-side request port and a backing memory that moves whole lines. It stores 256 data bytes as 4 sets of 2 ways with 32-byte lines. Each 12-bit address is split into an offset, a set index and a tag. Both ways of the selected set are compared in parallel. A hit returns or updates one byte after a fixed hit latency.

On a miss the controller picks a way in the set. An empty way is taken first. When both ways are valid, the controller takes the way that was not most recently used. A victim that holds modified data is written back as a full line before the refill read goes out. Writes use write-back with write-allocate. A write hit touches only the cached line. A write miss fetches the line first and then merges the new byte into it.

The processor issues one request at a time with a valid/ready handshake. It receives a one-cycle response pulse with the byte. The memory side gets one-cycle request pulses and answers each one with a one-cycle response pulse. A response pulse acknowledges a write-back or carries the fill data.

Top module: `cache2w_wb`

## Requirements
- R1: Address fields are offset = addr[4:0], set = addr[6:5], tag = addr[11:7]. Every memory request carries a line-aligned address (offset bits zero). A refill uses the request's own tag and set.
- R2: After reset every line is invalid, req_ready is high and rsp_valid is low. The first access to any line misses and issues a memory read.
- R3: A read hit returns the byte at the offset with no memory traffic. The one-cycle rsp_valid pulse is sampled high at the 3rd rising edge after the accepting edge.
- R4: A read miss issues one memory read for the line and installs the 32 returned bytes. It answers with the addressed byte.
- R5: On a miss, an invalid way in the selected set is filled before any valid line is evicted.
- R6: Each set keeps one most-recently-used marker, updated on every hit and every fill. When both ways are valid, the victim is the way the marker does not point to.
- R7: A write hit changes only the cached line and marks it dirty. No memory request is made, and later reads of the byte return the written value.
- R8: A write miss fetches the line, merges the written byte and marks the line dirty. The other bytes keep their memory values.
- R9: A dirty victim's full line is written to memory at {stored tag, set, 5'b0}. This write is acknowledged before the refill read is issued, so a dirty miss is sampled at edge 2*125+2 after acceptance.
- R10: A clean victim is replaced without a write-back, and a miss is then sampled at edge 125+2. A read fill leaves the line clean.
- R11: req_ready is high only while the cache is idle. Each accepted request yields exactly one single-cycle rsp_valid pulse.
- R12: mem_req_valid is a one-cycle pulse, and at most one memory request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache idle and able to take a request |
| req_write | input | 1 | 1 = store byte, 0 = load byte |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte at the address after the access |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 12 | Line-aligned memory address |
| mem_wdata | output | 256 | Line written back (byte i at bits 8i+7:8i) |
| mem_rsp_valid | input | 1 | Memory completion pulse |
| mem_rdata | input | 256 | Fill line (byte i at bits 8i+7:8i) |

## Verification
The tests use access patterns built to separate the three kinds of outcome: a hit, a clean miss and a dirty miss. Response latency and the logged memory traffic tell each kind apart. The patterns are:
- repeated reads inside one line;
- a second tag in a partly filled set;
- a third tag that arrives after a hit has moved the recency marker;
- writes that hit;
- writes that miss.

Dirty-eviction cases compare the whole written-back line against a shadow of expected memory. A line that was refilled after a write-back is evicted again to show that a read fill leaves the line clean.

// File: rtl/cache_pkg.sv
// Shared definitions for the two-way cache.
// Assumes exactly two ways, so one recency bit per set is enough.
package cache_pkg;
    localparam int WAYS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_HWAIT,
        ST_WB,
        ST_FILL
    } cstate_t;
endpackage

// File: rtl/cache_tag_store.sv
// Per-line valid, dirty and tag bits, plus one recency bit per set.
// Reads are combinational on rd_set. One line write and one recency
// write may happen on the same edge, both aimed at wr_set.
module cache_tag_store
    import cache_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int TAG_W = 5,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic                        rd_mru,
    input  logic [SET_W-1:0]            wr_set,
    input  logic                        wr_en,
    input  logic                        wr_way,
    input  logic                        wr_dirty,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        mru_en,
    input  logic                        mru_way
);
    logic [SETS-1:0][WAYS-1:0]            valid_q;
    logic [SETS-1:0][WAYS-1:0]            dirty_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0]                      mru_q;

    // Line state and recency update; reset leaves the cache cold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            tag_q   <= '0;
            mru_q   <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_set][wr_way] <= 1'b1;
                dirty_q[wr_set][wr_way] <= wr_dirty;
                tag_q[wr_set][wr_way]   <= wr_tag;
            end
            if (mru_en) begin
                mru_q[wr_set] <= mru_way;
            end
        end
    end

    // Present the selected set's lines to the lookup logic.
    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_valid[w] = valid_q[rd_set][w];
        assign rd_dirty[w] = dirty_q[rd_set][w];
        assign rd_tag[w]   = tag_q[rd_set][w];
    end
    assign rd_mru = mru_q[rd_set];

    a_r2_cold_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));
    a_r9_dirty_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((dirty_q & ~valid_q) == '0));
    a_r6_mru_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        mru_en |=> (mru_q[$past(wr_set)] == $past(mru_way)));
endmodule

// File: rtl/cache_data_store.sv
// Line data storage for all sets and ways, with one combinational read
// port and one full-line write port. Data is left unreset; valid bits
// elsewhere keep stale data from being used.
module cache_data_store
    import cache_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int LINE_W = 256,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  rd_set,
    input  logic              rd_way,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic              wr_way,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_q [SETS][WAYS];

    // Full-line write for both fills and merged byte stores.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_set][rd_way];
endmodule

// File: rtl/cache_way_match.sv
// Compares the request tag against both ways of a set at once, and
// names the victim: an invalid way first, else the way that was not
// most recently used.
module cache_way_match
    import cache_pkg::*;
#(
    parameter int TAG_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           req_tag,
    input  logic                       set_mru,
    output logic                       hit,
    output logic                       hit_way,
    output logic                       victim_way
);
    logic [WAYS-1:0] match;

    // Per-way tag comparator.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    // Hit reduction and victim choice.
    always_comb begin
        hit     = |match;
        hit_way = match[1];
        if (!way_valid[0])      victim_way = 1'b0;
        else if (!way_valid[1]) victim_way = 1'b1;
        else                    victim_way = ~set_mru;
    end

    a_r1_tag_unique_in_set: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/cache_ctrl.sv
// Request sequencer: takes one processor request, looks it up, waits
// out the hit latency or runs write-back and refill on the memory port,
// then pulses the response. HIT_LAT must be at least 3.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int OFF_W   = 5,
    parameter int SET_W   = 2,
    parameter int HIT_LAT = 3,
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int LINE_W = 8 << OFF_W,
    localparam int CNT_W  = $clog2(HIT_LAT + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [7:0]                 req_wdata,
    output logic                       rsp_valid,
    output logic [7:0]                 rsp_rdata,
    output logic                       mem_req_valid,
    output logic                       mem_req_write,
    output logic [ADDR_W-1:0]          mem_req_addr,
    input  logic                       mem_rsp_valid,
    input  logic [LINE_W-1:0]          mem_rdata,
    output logic [SET_W-1:0]           lk_set,
    output logic [TAG_W-1:0]           lk_tag,
    input  logic                       hit,
    input  logic                       hit_way,
    input  logic                       victim_way,
    input  logic [WAYS-1:0]            way_dirty,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    output logic                       rd_way,
    input  logic [LINE_W-1:0]          rd_line,
    output logic                       tag_we,
    output logic                       tag_way,
    output logic                       tag_dirty,
    output logic                       mru_we,
    output logic                       mru_way,
    output logic                       data_we,
    output logic                       data_way,
    output logic [LINE_W-1:0]          data_line
);
    cstate_t           state;
    logic [CNT_W-1:0]  cnt;
    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [7:0]        r_wdata;
    logic              vic_q;
    logic [OFF_W-1:0]  lk_off;

    assign lk_off = r_addr[OFF_W-1:0];
    assign lk_set = r_addr[OFF_W +: SET_W];
    assign lk_tag = r_addr[ADDR_W-1 -: TAG_W];

    function automatic logic [LINE_W-1:0] put_byte(input logic [LINE_W-1:0] line,
                                                   input logic [OFF_W-1:0]  off,
                                                   input logic [7:0]        b);
        logic [LINE_W-1:0] res;
        res = line;
        res[{off, 3'b000} +: 8] = b;
        return res;
    endfunction

    assign req_ready = (state == ST_IDLE);
    assign rd_way    = (state == ST_LOOKUP) ? hit_way : vic_q;

    // Store write controls for write hits and line fills.
    always_comb begin
        tag_we    = 1'b0;
        tag_way   = 1'b0;
        tag_dirty = 1'b0;
        mru_we    = 1'b0;
        mru_way   = 1'b0;
        data_we   = 1'b0;
        data_way  = 1'b0;
        data_line = rd_line;
        if (state == ST_LOOKUP && hit) begin
            mru_we  = 1'b1;
            mru_way = hit_way;
            if (r_write) begin
                tag_we    = 1'b1;
                tag_way   = hit_way;
                tag_dirty = 1'b1;
                data_we   = 1'b1;
                data_way  = hit_way;
                data_line = put_byte(rd_line, lk_off, r_wdata);
            end
        end else if (state == ST_FILL && mem_rsp_valid) begin
            mru_we    = 1'b1;
            mru_way   = vic_q;
            tag_we    = 1'b1;
            tag_way   = vic_q;
            tag_dirty = r_write;
            data_we   = 1'b1;
            data_way  = vic_q;
            data_line = r_write ? put_byte(mem_rdata, lk_off, r_wdata) : mem_rdata;
        end
    end

    // Sequencer: handshake, hit delay, write-back, refill and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cnt           <= '0;
            r_write       <= 1'b0;
            r_addr        <= '0;
            r_wdata       <= '0;
            vic_q         <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_addr  <= '0;
        end else begin
            rsp_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_write <= req_write;
                        r_addr  <= req_addr;
                        r_wdata <= req_wdata;
                        cnt     <= CNT_W'(1);
                        state   <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        rsp_rdata <= r_write ? r_wdata : rd_line[{lk_off, 3'b000} +: 8];
                        cnt       <= cnt + 1'b1;
                        state     <= ST_HWAIT;
                    end else begin
                        vic_q         <= victim_way;
                        mem_req_valid <= 1'b1;
                        if (way_dirty[victim_way]) begin
                            mem_req_write <= 1'b1;
                            mem_req_addr  <= {way_tag[victim_way], lk_set, {OFF_W{1'b0}}};
                            state         <= ST_WB;
                        end else begin
                            mem_req_write <= 1'b0;
                            mem_req_addr  <= {lk_tag, lk_set, {OFF_W{1'b0}}};
                            state         <= ST_FILL;
                        end
                    end
                end
                ST_HWAIT: begin
                    if (cnt >= CNT_W'(HIT_LAT - 1)) begin
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WB: begin
                    if (mem_rsp_valid) begin
                        mem_req_valid <= 1'b1;
                        mem_req_write <= 1'b0;
                        mem_req_addr  <= {lk_tag, lk_set, {OFF_W{1'b0}}};
                        state         <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_rsp_valid) begin
                        rsp_rdata <= r_write ? r_wdata : mem_rdata[{lk_off, 3'b000} +: 8];
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r11_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r12_mem_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    a_r12_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (state == ST_WB || state == ST_FILL));
    a_r9_fill_follows_wb_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && mem_rsp_valid) |=> (mem_req_valid && !mem_req_write));
    a_r1_fill_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |->
            (mem_req_addr == {r_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));
    a_r3_hit_no_mem_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HWAIT) |-> !mem_req_valid);
endmodule

// File: rtl/cache2w_wb.sv
// Top of the two-way write-back, write-allocate data cache. Joins the
// tag store, data store, way comparator and sequencer. Assumes SETS is
// a power of two of at least 2 and LINE_BYTES is a power of two.
module cache2w_wb
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 4,
    parameter int HIT_LAT    = 3,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rdata
);
    logic [SET_W-1:0]           lk_set;
    logic [TAG_W-1:0]           lk_tag;
    logic [WAYS-1:0]            way_valid;
    logic [WAYS-1:0]            way_dirty;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic                       set_mru;
    logic                       hit, hit_way, victim_way;
    logic                       rd_way;
    logic [LINE_W-1:0]          rd_line;
    logic                       tag_we, tag_way, tag_dirty;
    logic                       mru_we, mru_way;
    logic                       data_we, data_way;
    logic [LINE_W-1:0]          data_line;

    cache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_set(lk_set),
        .rd_valid(way_valid), .rd_dirty(way_dirty), .rd_tag(way_tag), .rd_mru(set_mru),
        .wr_set(lk_set), .wr_en(tag_we), .wr_way(tag_way), .wr_dirty(tag_dirty),
        .wr_tag(lk_tag), .mru_en(mru_we), .mru_way(mru_way)
    );

    cache_data_store #(.SETS(SETS), .LINE_W(LINE_W)) u_data (
        .clk(clk), .rd_set(lk_set), .rd_way(rd_way), .rd_line(rd_line),
        .wr_en(data_we), .wr_set(lk_set), .wr_way(data_way), .wr_line(data_line)
    );

    cache_way_match #(.TAG_W(TAG_W)) u_match (
        .clk(clk), .rst_n(rst_n), .way_valid(way_valid), .way_tag(way_tag),
        .req_tag(lk_tag), .set_mru(set_mru),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
    );

    cache_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .HIT_LAT(HIT_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .lk_set(lk_set), .lk_tag(lk_tag),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way),
        .way_dirty(way_dirty), .way_tag(way_tag),
        .rd_way(rd_way), .rd_line(rd_line),
        .tag_we(tag_we), .tag_way(tag_way), .tag_dirty(tag_dirty),
        .mru_we(mru_we), .mru_way(mru_way),
        .data_we(data_we), .data_way(data_way), .data_line(data_line)
    );

    // During a write-back the read port points at the chosen victim.
    assign mem_wdata = rd_line;
endmodule

// File: tb/cache2w_wb_test.sv
// Directed bench: a 4 KiB byte memory with a fixed-latency line port,
// a shadow of expected byte values, and one task per scenario.
module cache2w_wb_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 125;
    localparam int HIT_LAT    = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [7:0]   req_wdata = '0;
    logic         rsp_valid;
    logic [7:0]   rsp_rdata;
    logic         mem_req_valid;
    logic         mem_req_write;
    logic [11:0]  mem_req_addr;
    logic [255:0] mem_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rdata = '0;

    logic [7:0] mem_b  [4096];
    logic [7:0] shadow [4096];
    int         n_log;
    bit         log_wr   [8];
    logic [11:0] log_addr [8];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cache2w_wb uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Backing memory: logs each request and answers after MEM_LAT cycles.
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                if (n_log < 8) begin
                    log_wr[n_log]   = mem_req_write;
                    log_addr[n_log] = mem_req_addr;
                end
                n_log++;
                if (mem_req_write) begin
                    for (int i = 0; i < 32; i++)
                        mem_b[{mem_req_addr[11:5], 5'b0} + i] = mem_wdata[i*8 +: 8];
                end
                repeat (MEM_LAT - 1) @(negedge clk);
                for (int i = 0; i < 32; i++)
                    mem_rdata[i*8 +: 8] = mem_b[{mem_req_addr[11:5], 5'b0} + i];
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // kind: 0 hit, 1 miss with clean victim, 2 miss with dirty victim at wb_addr.
    task automatic access(input bit wr, input logic [11:0] a, input logic [7:0] wd,
                          input int kind, input logic [11:0] wb_addr, input string rq);
        int lat;
        logic [7:0] exp;
        logic [11:0] blk;
        blk   = {a[11:5], 5'b0};
        n_log = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11", "ready while busy", req_ready, 0);
        lat = 1;
        while (!rsp_valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        if (wr) shadow[a] = wd;
        exp = shadow[a];
        chk(rsp_rdata == exp, rq, $sformatf("data @%0h", a), rsp_rdata, exp);
        case (kind)
            0: begin
                chk(lat == HIT_LAT, rq, "hit latency", lat, HIT_LAT);
                chk(n_log == 0, rq, "hit mem requests", n_log, 0);
            end
            1: begin
                chk(lat == MEM_LAT + 2, rq, "clean miss latency", lat, MEM_LAT + 2);
                chk(n_log == 1 && !log_wr[0] && log_addr[0] == blk, rq,
                    "clean miss fill only", {n_log, 4'(log_wr[0]), log_addr[0]},
                    {32'd1, 4'd0, blk});
            end
            default: begin
                chk(lat == 2 * MEM_LAT + 2, rq, "dirty miss latency", lat, 2 * MEM_LAT + 2);
                chk(n_log == 2 && log_wr[0] && log_addr[0] == wb_addr, "R9",
                    "write-back first", {n_log, 4'(log_wr[0]), log_addr[0]},
                    {32'd2, 4'd1, wb_addr});
                chk(!log_wr[1] && log_addr[1] == blk, "R9", "refill after write-back",
                    log_addr[1], blk);
                for (int i = 0; i < 32; i++) begin
                    if (mem_b[wb_addr + i] != shadow[wb_addr + i])
                        chk(1'b0, "R9", $sformatf("written line byte %0d", i),
                            mem_b[wb_addr + i], shadow[wb_addr + i]);
                end
                chk(1'b1, "R9", "written line compared", 0, 0);
            end
        endcase
        @(negedge clk);
        chk(!rsp_valid, "R11", "response single pulse", rsp_valid, 0);
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R2", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R2", "no response after reset", rsp_valid, 0);
        chk(mem_req_valid == 1'b0, "R12", "no mem request after reset", mem_req_valid, 0);
    endtask

    task automatic t_cold_and_hit;
        access(0, 12'h0A3, 0, 1, 0, "R2");   // R1/R4: tag 1 set 1, fill 0x0A0
        access(0, 12'h0BF, 0, 0, 0, "R3");   // last byte of same line
        access(0, 12'h0A0, 0, 0, 0, "R3");
    endtask

    task automatic t_empty_then_nmru;
        access(0, 12'h1A4, 0, 1, 0, "R5");   // other way of set 1 is empty
        access(0, 12'h0A3, 0, 0, 0, "R5");   // first line survived
        access(0, 12'h2A0, 0, 1, 0, "R6");   // hit above made 0x0A0 recent
        access(0, 12'h0A7, 0, 0, 0, "R6");   // 0x0A0 kept, 0x1A0 evicted
        access(0, 12'h1A4, 0, 1, 0, "R6");   // evicts 0x2A0
        access(0, 12'h1A5, 0, 0, 0, "R6");
    endtask

    task automatic t_write_hit_and_evict;
        access(0, 12'h140, 0, 1, 0, "R4");
        access(1, 12'h145, 8'h5A, 0, 0, "R7");
        chk(mem_b[12'h145] != 8'h5A || shadow[12'h145] == mem_b[12'h145] && 1'b0,
            "R7", "memory untouched by write hit", mem_b[12'h145], 0);
        access(0, 12'h145, 0, 0, 0, "R7");
        access(0, 12'h340, 0, 1, 0, "R5");
        access(0, 12'h541, 0, 2, 12'h140, "R9");
        access(0, 12'h145, 0, 1, 0, "R9");  // refetch holds written byte
        access(0, 12'h540, 0, 0, 0, "R6");
        access(0, 12'h740, 0, 1, 0, "R10"); // refilled line is clean
    endtask

    task automatic t_clean_set;
        access(0, 12'h060, 0, 1, 0, "R10");
        access(0, 12'h160, 0, 1, 0, "R10");
        access(0, 12'h27F, 0, 1, 0, "R10");
    endtask

    task automatic t_write_miss;
        access(1, 12'h00D, 8'hC3, 1, 0, "R8");
        access(0, 12'h00D, 0, 0, 0, "R8");
        access(0, 12'h00E, 0, 0, 0, "R8");
        access(0, 12'h080, 0, 1, 0, "R8");
        access(0, 12'h100, 0, 2, 12'h000, "R8");
        access(0, 12'h00D, 0, 1, 0, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem_b[i]  = 8'((i * 37) + (i >> 8) * 11 + 5);
            shadow[i] = mem_b[i];
        end
        n_log = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_and_hit();
        t_empty_then_nmru();
        t_write_hit_and_evict();
        t_clean_set();
        t_write_miss();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule